// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces the sync and window signals for a raster display: horizontal sync, vertical sync, a display-enable that is high over the visible area, and one-cycle strobes marking the start of each line and each frame. It advances one pixel on each clock where the pixel enable is high, so the pixel rate can be any integer fraction of the clock.

The position counters are 16-bit linear feedback shift registers rather than binary counters. A shift register only needs a small XOR term per step, with no carry chain, so the counter stays fast at any width. The cost moves to software: each threshold is loaded as the shift-register state reached after the wanted number of steps from the seed. Only equality is ever tested, so all thresholds are matched with equality comparators. The horizontal count origin sits at the start of horizontal sync: sync is programmed to begin at step 1, and the visible area begins at step `htotal - hsync_start`.

Top module: `vtg_lfsr_timing`

## Requirements
- R1: After reset every output is low. Until the first clock with `pix_en` high, the outputs stay low and the raster does not move. On any clock with `pix_en` low, `hsync`, `vsync` and `de` hold their values.
- R2: Each counter resets to 0xFFFF, and each step shifts it left by one bit. The new bit 0 is bit15 XOR bit4 XOR bit2 XOR bit1 of the old state. The first enabled clock after reset places both counters at step 0. The horizontal counter goes back to step 0 on the enabled clock after it equals `h_end`. A line therefore lasts N+1 enabled clocks when `h_end` holds the state of step N.
- R3: `hsync` rises on the enabled clock where the horizontal counter takes the value `hs_on`, and falls on the one where it takes `hs_off`. If both thresholds are equal, the rise wins.
- R4: A horizontal window flag is set when the horizontal counter takes the value `ha_on` and cleared when it takes `ha_off`. On each enabled clock, `de` is the AND of the horizontal and vertical window flags that result from that clock.
- R5: The vertical counter steps only on clocks that start a line. It goes back to step 0 on the line start after it equals `v_end`, so a frame holds N+1 lines when `v_end` holds the state of step N. `vsync` is set or cleared only at a line start, when the vertical counter takes the value `vs_on` or `vs_off`.
- R6: The vertical window flag is set at the line start where the vertical counter takes the value `va_on`, and cleared at the one where it takes `va_off`.
- R7: `sol` is high for exactly the one clock that follows each enabled clock that starts a line, including the first enabled clock after reset. It is low on every other clock.
- R8: `sof` is high for the one clock that follows an enabled clock that starts line 0: either the first one after reset or a vertical wrap. It is never high without `sol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel step enable |
| h_end | input | 16 | Horizontal wrap state |
| hs_on | input | 16 | Horizontal sync set state |
| hs_off | input | 16 | Horizontal sync clear state |
| ha_on | input | 16 | Horizontal window open state |
| ha_off | input | 16 | Horizontal window close state |
| v_end | input | 16 | Vertical wrap state |
| vs_on | input | 16 | Vertical sync set state |
| vs_off | input | 16 | Vertical sync clear state |
| va_on | input | 16 | Vertical window open state |
| va_off | input | 16 | Vertical window close state |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| sol | output | 1 | Start-of-line strobe |
| sof | output | 1 | Start-of-frame strobe |

## Verification
The generator is run through two frames of a small mode with `pix_en` held high, which shows line length, wrap points and each window edge. It is then run with `pix_en` gapped in an irregular pattern. That pattern separates holding on idle clocks from stepping, and shows whether the strobes drop between enabled clocks. A second mode, with different widths and offsets, is loaded after a fresh reset. It catches comparators wired to the wrong threshold, which a single mode could mask. Expected values come from a binary-count model whose thresholds are converted by stepping the shift register.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Index of each window flag inside the flag array of the top module.
  // The horizontal flags come first; the top relies on that order.
  typedef enum int {
    FL_HSYNC = 0,
    FL_HWIN  = 1,
    FL_VSYNC = 2,
    FL_VWIN  = 3
  } flag_idx_e;

  localparam int NUM_FLAGS = 4;
  localparam int NUM_HFLAGS = 2;
endpackage

// File: rtl/vtg_lfsr_ctr.sv
module vtg_lfsr_ctr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'h8016
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         restart,
  input  logic [W-1:0] end_st,
  output logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  localparam logic [W-1:0] SEED = '1;

  logic [W-1:0] cur_q;
  logic [W-1:0] stepped;
  logic         fb;

  always_comb begin
    fb      = ^(cur_q & TAPS);
    stepped = {cur_q[W-2:0], fb};
    wrap    = (cur_q == end_st);
    nxt     = (restart || wrap) ? SEED : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= SEED;
    end else if (adv) begin
      cur_q <= nxt;
    end
  end

  assign cur = cur_q;
endmodule

// File: rtl/vtg_win_flag.sv
module vtg_win_flag #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] probe,
  input  logic [W-1:0] on_st,
  input  logic [W-1:0] off_st,
  output logic         q,
  output logic         d
);
  logic q_r;

  always_comb begin
    d = q_r;
    if (en) begin
      if (probe == on_st) begin
        d = 1'b1;
      end else if (probe == off_st) begin
        d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else begin
      q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/vtg_lfsr_timing.sv
module vtg_lfsr_timing #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'h8016
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_en,
  input  logic [W-1:0] h_end,
  input  logic [W-1:0] hs_on,
  input  logic [W-1:0] hs_off,
  input  logic [W-1:0] ha_on,
  input  logic [W-1:0] ha_off,
  input  logic [W-1:0] v_end,
  input  logic [W-1:0] vs_on,
  input  logic [W-1:0] vs_off,
  input  logic [W-1:0] va_on,
  input  logic [W-1:0] va_off,
  output logic         hsync,
  output logic         vsync,
  output logic         de,
  output logic         sol,
  output logic         sof
);
  import vtg_pkg::*;

  logic         run_q, run_d;
  logic         de_q, de_d;
  logic         sol_q, sol_d;
  logic         sof_q, sof_d;
  logic         line_adv;
  logic         h_wrap, v_wrap;
  logic [W-1:0] h_st, h_nxt, v_st, v_nxt;

  logic [W-1:0] fl_on    [NUM_FLAGS];
  logic [W-1:0] fl_off   [NUM_FLAGS];
  logic [NUM_FLAGS-1:0] fl_q, fl_d;

  vtg_lfsr_ctr #(.W(W), .TAPS(TAPS)) u_hctr (
    .clk(clk), .rst_n(rst_n), .adv(pix_en), .restart(!run_q),
    .end_st(h_end), .cur(h_st), .nxt(h_nxt), .wrap(h_wrap)
  );

  vtg_lfsr_ctr #(.W(W), .TAPS(TAPS)) u_vctr (
    .clk(clk), .rst_n(rst_n), .adv(line_adv), .restart(!run_q),
    .end_st(v_end), .cur(v_st), .nxt(v_nxt), .wrap(v_wrap)
  );

  always_comb begin
    fl_on[FL_HSYNC]  = hs_on;  fl_off[FL_HSYNC] = hs_off;
    fl_on[FL_HWIN]   = ha_on;  fl_off[FL_HWIN]  = ha_off;
    fl_on[FL_VSYNC]  = vs_on;  fl_off[FL_VSYNC] = vs_off;
    fl_on[FL_VWIN]   = va_on;  fl_off[FL_VWIN]  = va_off;
  end

  // Horizontal flags watch the next pixel position on every enabled step,
  // vertical flags watch the next line position at line starts only.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    if (i < NUM_HFLAGS) begin : g_h
      vtg_win_flag #(.W(W)) u_flag (
        .clk(clk), .rst_n(rst_n), .en(pix_en), .probe(h_nxt),
        .on_st(fl_on[i]), .off_st(fl_off[i]), .q(fl_q[i]), .d(fl_d[i])
      );
    end else begin : g_v
      vtg_win_flag #(.W(W)) u_flag (
        .clk(clk), .rst_n(rst_n), .en(line_adv), .probe(v_nxt),
        .on_st(fl_on[i]), .off_st(fl_off[i]), .q(fl_q[i]), .d(fl_d[i])
      );
    end
  end

  always_comb begin
    line_adv = pix_en && (!run_q || h_wrap);
    run_d    = run_q | pix_en;
    sol_d    = line_adv;
    sof_d    = line_adv && (!run_q || v_wrap);
    de_d     = pix_en ? (fl_d[FL_HWIN] & fl_d[FL_VWIN]) : de_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      de_q  <= 1'b0;
      sol_q <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      run_q <= run_d;
      de_q  <= de_d;
      sol_q <= sol_d;
      sof_q <= sof_d;
    end
  end

  assign hsync = fl_q[FL_HSYNC];
  assign vsync = fl_q[FL_VSYNC];
  assign de    = de_q;
  assign sol   = sol_q;
  assign sof   = sof_q;
endmodule

// File: rtl/vtg_lfsr_timing_chk.sv
module vtg_lfsr_timing_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pix_en,
  input logic         hsync,
  input logic         vsync,
  input logic         de,
  input logic         sol,
  input logic         sof,
  input logic         run,
  input logic         h_wrap,
  input logic [W-1:0] h_st,
  input logic         vwin
);
  localparam logic [W-1:0] SEED = '1;

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable({hsync, vsync, de}));

  a_r7_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> (!sol && !sof));

  a_r8_sof_with_sol: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> sol);

  a_r5_vsync_at_line: assert property (@(posedge clk) disable iff (!rst_n)
    !sol |-> $stable(vsync));

  a_r6_vwin_at_line: assert property (@(posedge clk) disable iff (!rst_n)
    !sol |-> $stable(vwin));

  a_r2_hwrap_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && run && h_wrap) |=> (h_st == SEED && sol));
endmodule

bind vtg_lfsr_timing vtg_lfsr_timing_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
  .de(de), .sol(sol), .sof(sof), .run(run_q), .h_wrap(h_wrap), .h_st(h_st),
  .vwin(fl_q[vtg_pkg::FL_VWIN])
);

// File: tb/sim_vtg_lfsr_timing.sv
module sim_vtg_lfsr_timing;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_en;
  logic [W-1:0] h_end, hs_on, hs_off, ha_on, ha_off;
  logic [W-1:0] v_end, vs_on, vs_off, va_on, va_off;
  logic hsync, vsync, de, sol, sof;

  always #4 clk = ~clk;

  vtg_lfsr_timing u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .h_end(h_end), .hs_on(hs_on), .hs_off(hs_off), .ha_on(ha_on), .ha_off(ha_off),
    .v_end(v_end), .vs_on(vs_on), .vs_off(vs_off), .va_on(va_on), .va_off(va_off),
    .hsync(hsync), .vsync(vsync), .de(de), .sol(sol), .sof(sof)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // expected item: {hsync, vsync, de, sol, sof}
  logic [4:0] exp_q[$];

  // binary-count reference model state and thresholds
  int m_ht, m_hs_on, m_hs_off, m_ha_on, m_ha_off;
  int m_vend, m_vs_on, m_vs_off, m_va_on, m_va_off;
  bit m_run;
  int hc, vc;
  bit m_hs, m_ha, m_vs, m_va, m_de;

  function automatic logic [W-1:0] lfsr_of(int n);
    logic [W-1:0] s = '1;
    for (int k = 0; k < n; k++) s = {s[W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic chk(string req, string nm, logic act, logic ex);
    n_chk++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, nm, act, ex, $time);
    end
  endtask

  task automatic setup(int ht, int hss, int hsw, int hact, int vt, int vss, int vsw, int vact);
    m_ht = ht;  m_hs_on = 1;  m_hs_off = hsw + 1;
    m_ha_on = ht - hss;  m_ha_off = ht - hss + hact;
    m_vend = vt;  m_vs_on = 0;  m_vs_off = vsw;
    m_va_on = vt - vss;  m_va_off = vt - vss + vact;
    h_end  = lfsr_of(ht - 1);
    hs_on  = lfsr_of(m_hs_on);   hs_off = lfsr_of(m_hs_off);
    ha_on  = lfsr_of(m_ha_on);   ha_off = lfsr_of(m_ha_off);
    v_end  = lfsr_of(vt);
    vs_on  = lfsr_of(m_vs_on);   vs_off = lfsr_of(m_vs_off);
    va_on  = lfsr_of(m_va_on);   va_off = lfsr_of(m_va_off);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_en = 1'b0;
    m_run = 0; hc = 0; vc = 0;
    m_hs = 0; m_ha = 0; m_vs = 0; m_va = 0; m_de = 0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    // R1: reset state
    chk("R1", "hsync", hsync, 1'b0);
    chk("R1", "vsync", vsync, 1'b0);
    chk("R1", "de", de, 1'b0);
    chk("R1", "sol", sol, 1'b0);
    chk("R1", "sof", sof, 1'b0);
    rst_n = 1'b1;
  endtask

  // driver: applies one clock of stimulus and pushes what the model expects
  task automatic step(bit en);
    bit line = 0, frame = 0;
    @(negedge clk);
    pix_en = en;
    if (en) begin
      if (!m_run) begin
        m_run = 1; hc = 0; vc = 0; line = 1; frame = 1;
      end else if (hc == m_ht - 1) begin
        hc = 0; line = 1;
        if (vc == m_vend) begin vc = 0; frame = 1; end
        else vc++;
      end else begin
        hc++;
      end
      if (hc == m_hs_on) m_hs = 1; else if (hc == m_hs_off) m_hs = 0;
      if (hc == m_ha_on) m_ha = 1; else if (hc == m_ha_off) m_ha = 0;
      if (line) begin
        if (vc == m_vs_on) m_vs = 1; else if (vc == m_vs_off) m_vs = 0;
        if (vc == m_va_on) m_va = 1; else if (vc == m_va_off) m_va = 0;
      end
      m_de = m_ha & m_va;
    end
    exp_q.push_back({m_hs, m_vs, m_de, line, frame});
  endtask

  // monitor: compares after every rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      e = exp_q.pop_front();
      chk("R3", "hsync", hsync, e[4]);
      chk("R5", "vsync", vsync, e[3]);
      chk("R4 R6", "de", de, e[2]);
      chk("R2 R7", "sol", sol, e[1]);
      chk("R8", "sof", sof, e[0]);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pix_en = 1'b0;
    setup(12, 8, 2, 6, 7, 5, 2, 4);
    do_reset();
    // R1: idle clocks before the first enable keep everything low
    for (int i = 0; i < 4; i++) step(0);
    // two frames with continuous enable (R2..R8)
    for (int i = 0; i < 192; i++) step(1);
    // gapped enable: holds and strobe drop (R1, R7)
    for (int i = 0; i < 300; i++) step((i % 3) != 1 && (i % 7) != 0);
    // second mode after a fresh reset
    setup(20, 14, 3, 10, 9, 7, 3, 5);
    repeat (2) @(negedge clk);
    do_reset();
    for (int i = 0; i < 3; i++) step(0);
    for (int i = 0; i < 420; i++) step(1);
    for (int i = 0; i < 120; i++) step((i % 4) != 3);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule